// File: doc/BRIEF.md
# Iterative TEA Block Cipher Core

This core encrypts or decrypts one 64-bit block under a 128-bit key with the Tiny Encryption Algorithm. The block is held as two 32-bit halves. The key is held as four 32-bit subkeys. Each half is mixed with 32-bit modular addition or subtraction, XOR and logical shifts, against a running sum that moves by the golden-ratio constant 0x9E3779B9 once per cycle. There are no substitution or permutation tables.

Encryption starts the running sum at zero. Decryption starts it at the value the sum reaches after the last encryption cycle, and runs the half-updates in reverse order. The default build completes one full algorithm cycle (both half-updates) per clock. A build-time option completes one half-update per clock instead, which makes the adder path shorter and doubles the latency.

A key is captured into an internal register by a key-update request while the core is idle. A block is accepted by a start strobe while the core is idle. The result appears on a registered output together with a one-clock acknowledge.

Top module: `tea_core`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `blk_o` is 0, `busy_o` is 0 and `ack_o` is 0 until a block is accepted.
- R2: With `decrypt_i`=0, the result is the TEA encryption of `blk_i`. Half v0 is `blk_i[63:32]` and v1 is `blk_i[31:0]`. Subkey k0 is `key[127:96]`, k1 is `key[95:64]`, k2 is `key[63:32]` and k3 is `key[31:0]`. The sum starts at 0. Each cycle: sum += 0x9E3779B9; v0 += F(v1,k0,k1); v1 += F(v0,k2,k3), where F(x,ka,kb) = ((x<<4)+ka) ^ (x+sum) ^ ((x>>5)+kb) with a logical right shift. The result is `{v0,v1}` after 32 cycles.
- R3: With `decrypt_i`=1, the sum starts at 0xC6EF3720. Each cycle: v1 -= F(v0,k2,k3); v0 -= F(v1,k0,k1); sum -= 0x9E3779B9. Decrypting a ciphertext under the same key returns the plaintext.
- R4: A start seen while idle raises `busy_o` at the next edge. `busy_o` then stays high for exactly 32 clocks in the full-cycle build.
- R5: `ack_o` is high for exactly one clock. It rises at the edge where `busy_o` falls, and `blk_o` carries the new result in that same clock.
- R6: `blk_o` keeps its previous value while `busy_o` is high.
- R7: A start while `busy_o` is high is ignored. It changes neither the result, nor the busy duration, nor the key, and no further block follows.
- R8: A key-update request while `busy_o` is high is ignored. The key captured earlier stays in use for later blocks.
- R9: When a key update and a start arrive in the same idle clock, that block uses the newly captured key.
- R10: With `HALF_STEP`=1, one half-update is done per clock. `busy_o` stays high for 64 clocks and the results are identical to the full-cycle build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| decrypt_i | input | 1 | 0 = encrypt, 1 = decrypt; sampled with the start |
| key_upd_i | input | 1 | Key capture request; honoured only when idle |
| key_i | input | 128 | Key; k0 in the top 32 bits, k3 in the bottom 32 bits |
| blk_i | input | 64 | Input block; v0 in the top 32 bits |
| blk_o | output | 64 | Registered result |
| busy_o | output | 1 | High while a block is being processed |
| ack_o | output | 1 | One-clock pulse when a result is written |

## Verification
Two functions can fall in the same clock: key capture and block acceptance. The bench asserts both strobes together while the core is idle and requires the result to match a reference computed with the new key. It also raises a key request in the middle of a block and requires the following block to use the old key. A start raised in the middle of a block is likewise judged at the ports: the result must be unchanged, the busy window must keep its exact length, and no second block may follow.

// File: rtl/tea_pkg.sv
package tea_pkg;
  localparam int unsigned HW = 32;
  localparam logic [HW-1:0] DELTA = 32'h9E37_79B9;

  function automatic logic [HW-1:0] tea_mix(input logic [HW-1:0] x,
                                            input logic [HW-1:0] s,
                                            input logic [HW-1:0] ka,
                                            input logic [HW-1:0] kb);
    return ((x << 4) + ka) ^ (x + s) ^ ((x >> 5) + kb);
  endfunction
endpackage

// File: rtl/tea_key_reg.sv
module tea_key_reg #(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             busy,
  input  logic [KEY_W-1:0] key_i,
  output logic [KEY_W-1:0] key_q
);
  always_ff @(posedge clk) begin
    if (rst) key_q <= '0;
    else if (upd && !busy) key_q <= key_i;
  end

  // R8: key frozen during a block
  p_key_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(key_q));
endmodule

// File: rtl/tea_ctrl.sv
module tea_ctrl #(
  parameter int ROUNDS    = 32,
  parameter bit HALF_STEP = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic phase,
  output logic busy,
  output logic ack
);
  localparam int STEPS = ROUNDS * (HALF_STEP ? 2 : 1);
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [CNT_W-1:0] cnt;

  assign load   = start && !busy;
  assign step   = busy;
  assign finish = busy && (cnt == LAST);

  generate
    if (HALF_STEP) begin : g_half
      assign phase = cnt[0];
    end else begin : g_full
      assign phase = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      ack  <= 1'b0;
    end else begin
      ack <= finish;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: accepted start raises busy
  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R7: a start while busy does not restart the count
  p_cnt_advances_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
  // R5: acknowledge is a single pulse closing a busy window
  p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  p_ack_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
    ack |-> ($past(busy) && !busy));
endmodule

// File: rtl/tea_round_dp.sv
module tea_round_dp
  import tea_pkg::*;
#(
  parameter int ROUNDS    = 32,
  parameter bit HALF_STEP = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic            finish,
  input  logic            phase,
  input  logic            dec_i,
  input  logic [4*HW-1:0] key_i,
  input  logic [2*HW-1:0] blk_i,
  output logic [2*HW-1:0] blk_o
);
  localparam logic [HW-1:0] SUM_END = HW'(64'(ROUNDS) * 64'(DELTA));

  logic [HW-1:0] v0, v1, sum, v0_n, v1_n, sum_n;
  logic          dec_q;
  logic [HW-1:0] k0, k1, k2, k3;

  assign k0 = key_i[4*HW-1:3*HW];
  assign k1 = key_i[3*HW-1:2*HW];
  assign k2 = key_i[2*HW-1:HW];
  assign k3 = key_i[HW-1:0];

  generate
    if (HALF_STEP) begin : g_half
      always_comb begin
        v0_n  = v0;
        v1_n  = v1;
        sum_n = sum;
        if (!dec_q) begin
          if (!phase) begin
            sum_n = sum + DELTA;
            v0_n  = v0 + tea_mix(v1, sum_n, k0, k1);
          end else begin
            v1_n = v1 + tea_mix(v0, sum, k2, k3);
          end
        end else begin
          if (!phase) begin
            v1_n = v1 - tea_mix(v0, sum, k2, k3);
          end else begin
            v0_n  = v0 - tea_mix(v1, sum, k0, k1);
            sum_n = sum - DELTA;
          end
        end
      end
    end else begin : g_full
      logic [HW-1:0] s_up;
      assign s_up = sum + DELTA;
      always_comb begin
        if (!dec_q) begin
          sum_n = s_up;
          v0_n  = v0 + tea_mix(v1, s_up, k0, k1);
          v1_n  = v1 + tea_mix(v0_n, s_up, k2, k3);
        end else begin
          v1_n  = v1 - tea_mix(v0, sum, k2, k3);
          v0_n  = v0 - tea_mix(v1_n, sum, k0, k1);
          sum_n = sum - DELTA;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v0    <= '0;
      v1    <= '0;
      sum   <= '0;
      dec_q <= 1'b0;
      blk_o <= '0;
    end else begin
      if (load) begin
        v0    <= blk_i[2*HW-1:HW];
        v1    <= blk_i[HW-1:0];
        sum   <= dec_i ? SUM_END : '0;
        dec_q <= dec_i;
      end else if (step) begin
        v0  <= v0_n;
        v1  <= v1_n;
        sum <= sum_n;
      end
      if (finish) blk_o <= {v0_n, v1_n};
    end
  end

  // R2: encryption sum lands on the decryption start value
  p_enc_sum_end_r2: assert property (@(posedge clk) disable iff (rst)
    (finish && !dec_q) |-> (sum_n == SUM_END));
  // R3: decryption sum returns to zero
  p_dec_sum_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (finish && dec_q) |-> (sum_n == '0));
endmodule

// File: rtl/tea_core.sv
module tea_core #(
  parameter int ROUNDS    = 32,
  parameter bit HALF_STEP = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         decrypt_i,
  input  logic         key_upd_i,
  input  logic [127:0] key_i,
  input  logic [63:0]  blk_i,
  output logic [63:0]  blk_o,
  output logic         busy_o,
  output logic         ack_o
);
  logic         load, step, finish, phase, busy;
  logic [127:0] key_q;

  tea_key_reg #(.KEY_W(128)) u_key (
    .clk(clk), .rst(rst), .upd(key_upd_i), .busy(busy),
    .key_i(key_i), .key_q(key_q)
  );

  tea_ctrl #(.ROUNDS(ROUNDS), .HALF_STEP(HALF_STEP)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .load(load), .step(step),
    .finish(finish), .phase(phase), .busy(busy), .ack(ack_o)
  );

  tea_round_dp #(.ROUNDS(ROUNDS), .HALF_STEP(HALF_STEP)) u_dp (
    .clk(clk), .rst(rst), .load(load), .step(step), .finish(finish),
    .phase(phase), .dec_i(decrypt_i), .key_i(key_q), .blk_i(blk_i),
    .blk_o(blk_o)
  );

  assign busy_o = busy;

  // R6: result holds between acknowledges
  p_dout_held_r6: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> $stable(blk_o));
endmodule

// File: tb/tea_core_test.sv
module tea_core_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0, decrypt_i = 1'b0, key_upd_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [63:0]  blk_i = '0;
  logic [63:0]  blk_o, blk_h;
  logic         busy_o, ack_o, busy_h, ack_h;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  tea_core uut (
    .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
    .key_upd_i(key_upd_i), .key_i(key_i), .blk_i(blk_i),
    .blk_o(blk_o), .busy_o(busy_o), .ack_o(ack_o)
  );

  tea_core #(.HALF_STEP(1'b1)) uut_half (
    .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
    .key_upd_i(key_upd_i), .key_i(key_i), .blk_i(blk_i),
    .blk_o(blk_h), .busy_o(busy_h), .ack_o(ack_h)
  );

  function automatic logic [31:0] f(input logic [31:0] x, s, ka, kb);
    return ((x << 4) + ka) ^ (x + s) ^ ((x >> 5) + kb);
  endfunction

  function automatic logic [63:0] ref_tea(input logic [63:0] b,
                                          input logic [127:0] k,
                                          input logic dec);
    logic [31:0] a0, a1, s;
    a0 = b[63:32]; a1 = b[31:0];
    s = dec ? 32'hC6EF3720 : 32'h0;
    for (int i = 0; i < 32; i++) begin
      if (!dec) begin
        s  = s + 32'h9E3779B9;
        a0 = a0 + f(a1, s, k[127:96], k[95:64]);
        a1 = a1 + f(a0, s, k[63:32], k[31:0]);
      end else begin
        a1 = a1 - f(a0, s, k[63:32], k[31:0]);
        a0 = a0 - f(a1, s, k[127:96], k[95:64]);
        s  = s - 32'h9E3779B9;
      end
    end
    return {a0, a1};
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_key(input logic [127:0] k);
    @(negedge clk); key_i = k; key_upd_i = 1'b1;
    @(negedge clk); key_upd_i = 1'b0;
  endtask

  // Runs one block on uut; returns result and busy length.
  // Optional mid-block disturbances at the 5th busy clock.
  task automatic run_block(input logic [63:0] b, input logic dec,
                           input logic poke_start, input logic poke_key,
                           input logic [127:0] poke_k, input string req,
                           output logic [63:0] res, output int blen);
    logic [63:0] prev;
    int n;
    prev = blk_o;
    @(negedge clk); blk_i = b; decrypt_i = dec; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    n = 0;
    while (!ack_o && n < 200) begin
      if (busy_o) n++;
      if (blk_o !== prev) begin
        check({req, " R6 held during busy"}, blk_o, prev);
        prev = blk_o;
      end
      if (n == 5 && poke_start) begin
        blk_i = ~b; decrypt_i = ~dec; start_i = 1'b1;
      end
      if (n == 5 && poke_key) begin
        key_i = poke_k; key_upd_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0; key_upd_i = 1'b0;
    end
    check({req, " R5 busy low at ack"}, 64'(busy_o), 64'd0);
    res = blk_o;
    blen = n;
    @(negedge clk);
    check({req, " R5 ack one clock"}, 64'(ack_o), 64'd0);
  endtask

  task automatic t_reset;
    check("R1 blk_o after reset", blk_o, 64'h0);
    check("R1 busy after reset", 64'(busy_o), 64'd0);
    check("R1 ack after reset", 64'(ack_o), 64'd0);
  endtask

  task automatic t_encrypt_patterns;
    logic [63:0] r; int bl;
    logic [127:0] k;
    k = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    load_key(k);
    run_block(64'h0, 1'b0, 0, 0, '0, "R2", r, bl);
    check("R2 enc zero block", r, ref_tea(64'h0, k, 1'b0));
    check("R4 busy length 32", 64'(bl), 64'd32);
    run_block(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, 0, '0, "R2", r, bl);
    check("R2 enc all ones", r, ref_tea(64'hFFFF_FFFF_FFFF_FFFF, k, 1'b0));
    load_key('1);
    run_block(64'h8000_0001_DEAD_BEEF, 1'b0, 0, 0, '0, "R2", r, bl);
    check("R2 enc key all ones", r, ref_tea(64'h8000_0001_DEAD_BEEF, '1, 1'b0));
  endtask

  task automatic t_decrypt;
    logic [63:0] c, r; int bl;
    logic [127:0] k;
    k = 128'hA5A5_0F0F_1234_5678_C3C3_9999_0000_FFFF;
    load_key(k);
    run_block(64'h1357_9BDF_2468_ACE0, 1'b0, 0, 0, '0, "R3", c, bl);
    run_block(c, 1'b1, 0, 0, '0, "R3", r, bl);
    check("R3 decrypt round trip", r, 64'h1357_9BDF_2468_ACE0);
    run_block(64'hCAFE_F00D_0BAD_C0DE, 1'b1, 0, 0, '0, "R3", r, bl);
    check("R3 decrypt vs model", r, ref_tea(64'hCAFE_F00D_0BAD_C0DE, k, 1'b1));
    check("R4 decrypt busy length", 64'(bl), 64'd32);
  endtask

  task automatic t_start_while_busy;
    logic [63:0] r; int bl;
    logic [127:0] k;
    k = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    load_key(k);
    run_block(64'h0F1E_2D3C_4B5A_6978, 1'b0, 1, 0, '0, "R7", r, bl);
    check("R7 result unaffected", r, ref_tea(64'h0F1E_2D3C_4B5A_6978, k, 1'b0));
    check("R7 busy length kept", 64'(bl), 64'd32);
    check("R7 no second block", 64'(busy_o), 64'd0);
  endtask

  task automatic t_key_while_busy;
    logic [63:0] r; int bl;
    logic [127:0] ka, kb;
    ka = 128'hDEAD_0001_BEEF_0002_CAFE_0003_F00D_0004;
    kb = ~ka;
    load_key(ka);
    run_block(64'h1, 1'b0, 0, 1, kb, "R8", r, bl);
    check("R8 block during request", r, ref_tea(64'h1, ka, 1'b0));
    run_block(64'h2, 1'b0, 0, 0, '0, "R8", r, bl);
    check("R8 old key kept", r, ref_tea(64'h2, ka, 1'b0));
  endtask

  task automatic t_key_with_start;
    logic [63:0] r; int n;
    logic [127:0] kc;
    kc = 128'h0BAD_F00D_1234_4321_ABCD_DCBA_5A5A_A5A5;
    @(negedge clk);
    key_i = kc; key_upd_i = 1'b1;
    blk_i = 64'h7777_0000_3333_1111; decrypt_i = 1'b0; start_i = 1'b1;
    @(negedge clk); key_upd_i = 1'b0; start_i = 1'b0;
    n = 0;
    while (!ack_o && n < 200) begin n++; @(negedge clk); end
    r = blk_o;
    check("R9 same-clock key and start", r, ref_tea(64'h7777_0000_3333_1111, kc, 1'b0));
    @(negedge clk);
  endtask

  task automatic t_half_step;
    logic [127:0] kh;
    int n;
    kh = 128'h9E37_79B9_0000_0001_7F7F_7F7F_8080_8080;
    while (busy_h || busy_o) @(negedge clk);
    load_key(kh);
    @(negedge clk); blk_i = 64'h0123_4567_89AB_CDEF; decrypt_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    n = 0;
    while (!ack_h && n < 300) begin if (busy_h) n++; @(negedge clk); end
    check("R10 half-step busy length", 64'(n), 64'd64);
    check("R10 half-step result", blk_h, ref_tea(64'h0123_4567_89AB_CDEF, kh, 1'b0));
    @(negedge clk);
    check("R10 half-step ack one clock", 64'(ack_h), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_encrypt_patterns();
    t_decrypt();
    t_start_while_busy();
    t_key_while_busy();
    t_key_with_start();
    t_half_step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule